// File: doc/BRIEF.md
# Transmit Sample Queue with Underrun Hold

This block buffers outgoing samples for a serial audio or modem link. A DMA-style writer pushes 32-bit samples into a 16-entry queue. A slot-rate consumer pulls one sample per frame. The pulled sample appears on a registered output one clock after the request.

When the consumer asks for a sample and the queue is empty, the block does not move either pointer. It keeps presenting the last sample it delivered, so the link repeats that value instead of sending garbage. It also sets a sticky error flag. Software clears the flag by writing a one to its bit. A separate enable bit turns the flag into a level interrupt.

Two word registers make up the software view. Word address 0 is the control register and word address 1 is the status register. Addresses 2 and 3 read as zero.

Top module: `txq_top`

## Requirements
- R1: After reset, `slot_data` is 0, `irq` is 0, `tx_empty` is 1, `wr_full` is 0, and both registers read 0.
- R2: Samples leave in the order they were accepted. `slot_data` takes the new sample on the clock edge that samples `slot_req`.
- R3: After 16 accepted writes with no reads, `wr_full` is 1. Any write while `wr_full` is 1 is discarded: it is never output and it does not set the error flag.
- R4: A `slot_req` while the queue is empty leaves `slot_data` unchanged and sets the error flag, which is status bit 4.
- R5: A `slot_req` on an empty queue does not advance the read or write pointer. A sample pushed afterwards is the next one output, and the queue then reads empty again.
- R6: The status bit 4 flag stays set until a status write with data bit 4 equal to 1. A status write with bit 4 equal to 0 leaves the flag unchanged.
- R7: If an underrun and a clearing status write happen in the same cycle, the flag ends up at 1.
- R8: Control bit 3 is the interrupt enable. `irq` is a register loaded each cycle with (enable AND flag). It rises one cycle after both are 1, falls one cycle after the flag is cleared, and stays 0 while the enable is 0.
- R9: Only control bit 3 and status bit 4 are writable or readable. Every other bit of both registers, and every bit at addresses 2 and 3, reads 0.
- R10: An underrun before any sample has been output presents 0 on `slot_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; internally released synchronously |
| wr_valid | input | 1 | Writer push strobe |
| wr_data | input | 32 | Sample to push |
| wr_full | output | 1 | Queue holds 16 samples |
| tx_empty | output | 1 | Queue holds no samples |
| slot_req | input | 1 | Consumer request for one sample |
| slot_data | output | 32 | Registered sample presented to the link |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register word address (0 control, 1 status) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| irq | output | 1 | Registered error interrupt level |

## Verification
Several behaviours are checked by the in-line properties on every cycle:
- output and read pointer hold still on an underrun;
- a push into a full queue leaves the write pointer alone;
- the occupancy never exceeds the depth;
- the flag obeys its set, clear and set-wins rules;
- `irq` follows the enabled flag one cycle later.

Other behaviours can only be shown by the directed scenarios:
- the order of samples across a full fill and drain;
- that a dropped 17th sample never reaches the link;
- the zero output on an early underrun;
- the masking of reserved bits as seen through software reads.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int unsigned SAMPLE_W   = 32;
  localparam int unsigned Q_DEPTH    = 16;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned REG_AW     = 2;
  localparam logic [REG_AW-1:0] CTRL_ADDR = 2'd0;
  localparam logic [REG_AW-1:0] STAT_ADDR = 2'd1;
  localparam int unsigned IE_BIT     = 3;
  localparam int unsigned ERR_BIT    = 4;
endpackage

// File: rtl/txq_rst_sync.sv
module txq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/txq_store.sv
module txq_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic              full,
  output logic              empty,
  output logic              underrun,
  output logic [DATA_W-1:0] out_data
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PW-1:0]     wptr_q, wptr_d, rptr_q, rptr_d;
  logic [DATA_W-1:0] out_q, out_d;
  logic              push_ok, pop_ok;
  logic [PW-1:0]     level;

  assign empty    = (wptr_q == rptr_q);
  assign full     = (wptr_q[AW] != rptr_q[AW]) && (wptr_q[AW-1:0] == rptr_q[AW-1:0]);
  assign push_ok  = push & ~full;
  assign pop_ok   = pop_req & ~empty;
  assign underrun = pop_req & empty;
  assign level    = wptr_q - rptr_q;
  assign out_data = out_q;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    out_d  = out_q;
    if (push_ok) wptr_d = wptr_q + PW'(1);
    if (pop_ok) begin
      rptr_d = rptr_q + PW'(1);
      out_d  = mem_q[rptr_q[AW-1:0]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      out_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      out_q  <= out_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (push_ok && (wptr_q[AW-1:0] == AW'(g))) mem_q[g] <= push_data;
    end
  end

  // R4
  hold_on_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty) |=> $stable(out_q));

  // R5
  rptr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty) |=> $stable(rptr_q));

  // R3
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> $stable(wptr_q));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= PW'(DEPTH));
endmodule

// File: rtl/txq_regs.sv
module txq_regs
  import txq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              underrun,
  output logic [REG_W-1:0]  rdata,
  output logic              irq
);
  logic ie_q, ie_d, err_q, err_d, irq_q, irq_d;
  logic ctrl_wr, stat_clr;
  logic unused_wdata;

  assign unused_wdata = ^{wdata[REG_W-1:ERR_BIT+1], wdata[IE_BIT-1:0]};
  assign ctrl_wr  = wr_en && (addr == CTRL_ADDR);
  assign stat_clr = wr_en && (addr == STAT_ADDR) && wdata[ERR_BIT];

  always_comb begin
    ie_d  = ctrl_wr ? wdata[IE_BIT] : ie_q;
    err_d = err_q;
    if (stat_clr) err_d = 1'b0;
    if (underrun) err_d = 1'b1;
    irq_d = ie_q & err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      err_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ie_q  <= ie_d;
      err_q <= err_d;
      irq_q <= irq_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      CTRL_ADDR: rdata[IE_BIT]  = ie_q;
      STAT_ADDR: rdata[ERR_BIT] = err_q;
      default:   rdata = '0;
    endcase
  end

  assign irq = irq_q;

  // R7
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> err_q);

  // R6
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !underrun) |=> !err_q);

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_clr && !underrun) |=> $stable(err_q));

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_q && err_q) |=> irq);

  // R8
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ie_q && err_q) |=> !irq);
endmodule

// File: rtl/txq_top.sv
module txq_top
  import txq_pkg::*;
#(
  parameter int unsigned DATA_W = SAMPLE_W,
  parameter int unsigned DEPTH  = Q_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  output logic              tx_empty,
  input  logic              slot_req,
  output logic [DATA_W-1:0] slot_data,
  input  logic              cfg_wr,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  output logic              irq
);
  logic rst_n_s;
  logic underrun;

  txq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  txq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .push      (wr_valid),
    .push_data (wr_data),
    .pop_req   (slot_req),
    .full      (wr_full),
    .empty     (tx_empty),
    .underrun  (underrun),
    .out_data  (slot_data)
  );

  txq_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_en    (cfg_wr),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .underrun (underrun),
    .rdata    (cfg_rdata),
    .irq      (irq)
  );
endmodule

// File: tb/txq_top_tb.sv
`timescale 1ns/1ps
module txq_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic        wr_full, tx_empty;
  logic        slot_req = 1'b0;
  logic [31:0] slot_data;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  txq_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_full(wr_full), .tx_empty(tx_empty), .slot_req(slot_req),
    .slot_data(slot_data), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(input logic [31:0] d);
    wr_valid = 1'b1; wr_data = d;
    step();
    wr_valid = 1'b0;
  endtask

  task automatic pop();
    slot_req = 1'b1;
    step();
    slot_req = 1'b0;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_wr = 1'b0; cfg_wdata = '0;
  endtask

  task automatic reg_check(input logic [1:0] a, input logic [31:0] exp, input string tag);
    cfg_addr = a;
    #1;
    check(cfg_rdata == exp, tag, cfg_rdata, exp);
  endtask

  task automatic t_reset();
    check(slot_data == 0, "R1 slot_data", slot_data, 0);
    check(irq == 0, "R1 irq", {31'b0, irq}, 0);
    check(tx_empty == 1, "R1 empty", {31'b0, tx_empty}, 1);
    check(wr_full == 0, "R1 full", {31'b0, wr_full}, 0);
    reg_check(2'd0, 32'h0, "R1 ctrl");
    reg_check(2'd1, 32'h0, "R1 status");
  endtask

  task automatic t_early_underrun();
    pop();
    check(slot_data == 0, "R10 zero on early underrun", slot_data, 0);
    reg_check(2'd1, 32'h10, "R4 flag set");
    reg_write(2'd1, 32'h0);
    reg_check(2'd1, 32'h10, "R6 write zero ignored");
    reg_write(2'd1, 32'hFFFF_FFEF);
    reg_check(2'd1, 32'h10, "R6 other bits do not clear");
    reg_write(2'd1, 32'h10);
    reg_check(2'd1, 32'h0, "R6 write one clears");
  endtask

  task automatic t_order();
    for (int i = 0; i < 5; i++) push(32'hA000_0000 + i);
    for (int i = 0; i < 5; i++) begin
      pop();
      check(slot_data == 32'hA000_0000 + i, "R2 order", slot_data, 32'hA000_0000 + i);
    end
    check(tx_empty == 1, "R2 drained", {31'b0, tx_empty}, 1);
    reg_check(2'd1, 32'h0, "R2 no error while data present");
    pop();
    check(slot_data == 32'hA000_0004, "R4 hold last", slot_data, 32'hA000_0004);
    pop();
    check(slot_data == 32'hA000_0004, "R4 hold repeat", slot_data, 32'hA000_0004);
    reg_check(2'd1, 32'h10, "R4 flag after underrun");
    reg_write(2'd1, 32'h10);
  endtask

  task automatic t_full();
    for (int i = 0; i < 16; i++) push(32'hB000_0000 + i);
    check(wr_full == 1, "R3 full after 16", {31'b0, wr_full}, 1);
    push(32'hDEAD_BEEF);
    check(wr_full == 1, "R3 still full", {31'b0, wr_full}, 1);
    reg_check(2'd1, 32'h0, "R3 drop not an error");
    for (int i = 0; i < 16; i++) begin
      pop();
      check(slot_data == 32'hB000_0000 + i, "R3 drain order", slot_data, 32'hB000_0000 + i);
    end
    check(tx_empty == 1, "R3 empty after drain", {31'b0, tx_empty}, 1);
    pop();
    check(slot_data == 32'hB000_000F, "R3 dropped word never output", slot_data, 32'hB000_000F);
    reg_write(2'd1, 32'h10);
  endtask

  task automatic t_pointers();
    pop(); pop(); pop();
    check(tx_empty == 1, "R5 empty after underruns", {31'b0, tx_empty}, 1);
    push(32'hC0DE_0001);
    check(tx_empty == 0, "R5 not empty after push", {31'b0, tx_empty}, 0);
    pop();
    check(slot_data == 32'hC0DE_0001, "R5 next sample", slot_data, 32'hC0DE_0001);
    check(tx_empty == 1, "R5 empty again", {31'b0, tx_empty}, 1);
    reg_write(2'd1, 32'h10);
  endtask

  task automatic t_set_wins();
    slot_req = 1'b1;
    cfg_wr = 1'b1; cfg_addr = 2'd1; cfg_wdata = 32'h10;
    step();
    slot_req = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0;
    reg_check(2'd1, 32'h10, "R7 set wins");
    reg_write(2'd1, 32'h10);
    reg_check(2'd1, 32'h0, "R7 cleared afterwards");
  endtask

  task automatic t_irq();
    pop();
    step();
    check(irq == 0, "R8 masked", {31'b0, irq}, 0);
    reg_write(2'd0, 32'h8);
    check(irq == 0, "R8 one cycle lag", {31'b0, irq}, 0);
    step();
    check(irq == 1, "R8 asserted", {31'b0, irq}, 1);
    reg_write(2'd1, 32'h10);
    check(irq == 1, "R8 lag on clear", {31'b0, irq}, 1);
    step();
    check(irq == 0, "R8 deasserted", {31'b0, irq}, 0);
    reg_write(2'd0, 32'h0);
  endtask

  task automatic t_reserved();
    reg_write(2'd0, 32'hFFFF_FFFF);
    reg_check(2'd0, 32'h8, "R9 ctrl mask");
    pop();
    reg_write(2'd1, 32'hFFFF_FFEF);
    reg_check(2'd1, 32'h10, "R9 status mask");
    reg_check(2'd2, 32'h0, "R9 addr2 zero");
    reg_check(2'd3, 32'h0, "R9 addr3 zero");
    reg_write(2'd0, 32'hFFFF_FFF7);
    reg_check(2'd0, 32'h0, "R9 ctrl cleared");
    reg_write(2'd1, 32'h10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_early_underrun();
    t_order();
    t_full();
    t_pointers();
    t_set_wins();
    t_irq();
    t_reserved();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule